// File: doc/BRIEF.md
# DDR Read Latency Pipeline

This block sits on the memory side of a double-data-rate read path. It accepts Read and Mode Register Set commands. It holds the operating settings those commands load, and it releases each read burst onto the data bus after a programmable CAS latency. The block is clocked at twice the CK rate. An internal phase register splits every CK period into a rising-edge slot and a falling-edge slot, so latencies of 1.5 and 2.5 clocks can place the first beat on a falling CK edge.

A command is accepted only in a rising-edge slot. A Read carries its four-beat burst on a wide input that stands in for the array. The beats then leave one per half-cycle, together with a valid strobe. A Mode Register Set decodes its operating-mode bits as one of three cases: normal operation, a DLL reset, or a reserved pattern. It also rejects latency codes that are not legal. After a DLL reset, anything other than a normal-mode load is reported as a sequence error. The error flags stay set until reset.

Top module: `cas_read_pipe`

## Requirements
- R1: A synchronous active-high reset sets `mode_o` to 7'b0100000 (latency 2), clears both error flags, empties the pipeline (`dqs_o`=0, `dq_o`=0) and sets `ck_phase_o` to 0.
- R2: `mode_o[6:4]` selects the latency: 010 = 2 clocks, 011 = 3, 110 = 2.5, 101 = 1.5. A Read accepted at an internal clock edge E puts its first beat on `dq_o` from edge E+2m, where m is the latency in clocks.
- R3: Code 101 (1.5 clocks) loads only while `slow_grade_i` is 1. With `slow_grade_i` at 0 the code is reserved: it sets `err_rsvd_o` and `mode_o` keeps its value.
- R4: Every Read produces four beats on consecutive internal cycles, in the order `burst_i[DW-1:0]` first up to the top slice last. `dqs_o` is high exactly during those beats, and `dq_o` is zero whenever `dqs_o` is low.
- R5: Reads accepted four internal cycles (two CK) apart produce a gapless stream: `dqs_o` stays high from the first beat of the first read to the last beat of the last read.
- R6: `cmd_i`=2'b10 (Mode Register Set) with `addr_i[12:7]`=0 and a legal latency code loads `addr_i[6:0]` into `mode_o`. `cmd_i`=2'b01 is Read, and 2'b00 or 2'b11 does nothing.
- R7: A Mode Register Set with `addr_i[12:7]`=6'b000010 and a legal latency code is a DLL reset. It also loads `addr_i[6:0]` and arms the requirement that a normal-mode load comes next.
- R8: While a DLL reset is armed, a Read, another DLL reset, or any Mode Register Set that does not load in normal mode sets `err_seq_o`. Only a successful normal-mode load disarms it.
- R9: Any other pattern on `addr_i[12:7]` sets `err_rsvd_o` and leaves `mode_o` unchanged.
- R10: A latency code outside the four legal values sets `err_rsvd_o` and leaves `mode_o` unchanged, even when the operating-mode bits are normal.
- R11: `ck_phase_o` toggles every internal cycle after reset. A command presented while `ck_phase_o` is 1 (falling slot) is ignored: it does not change the mode, the flags or the data output.
- R12: `err_seq_o` and `err_rsvd_o` stay set until reset, whatever commands follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the CK rate |
| rst | input | 1 | Synchronous active-high reset |
| cmd_i | input | 2 | Command: 00 none, 01 Read, 10 Mode Register Set, 11 none |
| addr_i | input | 13 | Address bits A12..A0; the mode load uses all of them |
| slow_grade_i | input | 1 | High when the part runs in the slowest speed grade |
| burst_i | input | BL*DW | Four read beats from the array stub, beat 0 in the low slice |
| ck_phase_o | output | 1 | 0 in a rising-CK slot, 1 in a falling-CK slot |
| dq_o | output | DW | Read data beat, zero when idle |
| dqs_o | output | 1 | High while a beat is on `dq_o` |
| mode_o | output | 7 | Current mode register contents |
| err_seq_o | output | 1 | Sticky DLL-reset sequence error |
| err_rsvd_o | output | 1 | Sticky reserved-code error |

## Verification
Directed reads run at each of the four latencies. The 1.5 and 2.5 cases show whether a beat lands on a falling slot, and comparing 2 with 3 exposes an off-by-one in the delay line. Back-to-back reads spaced two CK apart show whether there are gaps or overlaps between bursts. Mode loads are tried with normal, DLL-reset and reserved operating bits, with legal and illegal latency codes, and with code 101 under both speed grades. These cases separate the three rejection paths from the sequence rule. Random traffic then issues commands in both phase slots with random data and random speed-grade changes, which shows whether falling-slot commands are truly ignored and whether the flags stay set.

// File: rtl/cas_read_pkg.sv
package cas_read_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'b00,
        CMD_READ = 2'b01,
        CMD_LOAD = 2'b10,
        CMD_IDLE = 2'b11
    } cmd_e;

    localparam int ADDR_W = 13;
    localparam int MODE_W = 7;
    localparam int LAT_W  = 3;

    localparam logic [MODE_W-1:0] MODE_RESET  = 7'b010_0000;
    localparam logic [5:0]        OPM_NORMAL  = 6'b000000;
    localparam logic [5:0]        OPM_DLL_RST = 6'b000010;

    // Latency in internal half-CK cycles for a CAS code.
    function automatic logic [LAT_W-1:0] code_to_halves(input logic [2:0] code);
        case (code)
            3'b011:  return 3'd6;
            3'b101:  return 3'd3;
            3'b110:  return 3'd5;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic code_is_legal(input logic [2:0] code, input logic slow);
        case (code)
            3'b010, 3'b011, 3'b110: return 1'b1;
            3'b101:                 return slow;
            default:                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cas_mode_reg.sv
module cas_mode_reg
    import cas_read_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     load_fire,
    input  logic                     read_fire,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     slow_grade,
    output logic [MODE_W-1:0]        mode,
    output logic [LAT_W-1:0]         lat_halves,
    output logic                     err_seq,
    output logic                     err_rsvd
);

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              armed;
        logic              seq;
        logic              rsvd;
    } mreg_t;

    mreg_t cur_q, nxt_d;

    logic [5:0] opm;
    logic [2:0] code;
    logic       is_norm, is_dll, code_ok;

    always_comb begin
        opm     = addr[ADDR_W-1:MODE_W];
        code    = addr[6:4];
        is_norm = (opm == OPM_NORMAL);
        is_dll  = (opm == OPM_DLL_RST);
        code_ok = code_is_legal(code, slow_grade);

        nxt_d = cur_q;
        if (load_fire) begin
            if ((is_norm || is_dll) && code_ok) begin
                nxt_d.mode = addr[MODE_W-1:0];
            end else begin
                nxt_d.rsvd = 1'b1;
            end
            if (cur_q.armed && !(is_norm && code_ok)) begin
                nxt_d.seq = 1'b1;
            end
            if (is_dll && code_ok) begin
                nxt_d.armed = 1'b1;
            end else if (is_norm && code_ok) begin
                nxt_d.armed = 1'b0;
            end
        end
        if (read_fire && cur_q.armed) begin
            nxt_d.seq = 1'b1;
        end
        if (rst) begin
            nxt_d = '{mode: MODE_RESET, armed: 1'b0, seq: 1'b0, rsvd: 1'b0};
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign mode       = cur_q.mode;
    assign lat_halves = code_to_halves(cur_q.mode[6:4]);
    assign err_seq    = cur_q.seq;
    assign err_rsvd   = cur_q.rsvd;

endmodule

// File: rtl/cas_beat_line.sv
module cas_beat_line
    import cas_read_pkg::*;
#(
    parameter int DW       = 8,
    parameter int BL       = 4,
    parameter int MAX_HALF = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              read_fire,
    input  logic [LAT_W-1:0]  lat_halves,
    input  logic [BL*DW-1:0]  burst,
    output logic [DW-1:0]     dq,
    output logic              dqs
);

    localparam int DEPTH = MAX_HALF + BL;
    localparam int IW    = $clog2(DEPTH);

    typedef struct packed {
        logic          v;
        logic [DW-1:0] d;
    } beat_t;

    typedef struct packed {
        beat_t [DEPTH-1:0] slot;
    } line_t;

    line_t         cur_q, nxt_d;
    logic [IW-1:0] idx;

    // Slot j holds the beat that reaches the output j edges from now.
    always_comb begin
        idx = '0;
        for (int i = 0; i < DEPTH - 1; i++) begin
            nxt_d.slot[i] = cur_q.slot[i+1];
        end
        nxt_d.slot[DEPTH-1] = '0;
        if (read_fire) begin
            for (int k = 0; k < BL; k++) begin
                idx = IW'(lat_halves) + IW'(k);
                nxt_d.slot[idx] = '{v: 1'b1, d: burst[k*DW +: DW]};
            end
        end
        if (rst) begin
            nxt_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        cur_q <= nxt_d;
    end

    assign dqs = cur_q.slot[0].v;
    assign dq  = cur_q.slot[0].v ? cur_q.slot[0].d : '0;

endmodule

// File: rtl/cas_read_pipe.sv
module cas_read_pipe
    import cas_read_pkg::*;
#(
    parameter int DW       = 8,
    parameter int BL       = 4,
    parameter int MAX_HALF = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_i,
    input  logic [12:0]       addr_i,
    input  logic              slow_grade_i,
    input  logic [BL*DW-1:0]  burst_i,
    output logic              ck_phase_o,
    output logic [DW-1:0]     dq_o,
    output logic              dqs_o,
    output logic [6:0]        mode_o,
    output logic              err_seq_o,
    output logic              err_rsvd_o
);

    typedef struct packed {
        logic fall;
    } phase_t;

    phase_t ph_q, ph_d;
    cmd_e   cmd;
    logic   read_fire, load_fire;
    logic [LAT_W-1:0] lat_halves;

    always_comb begin
        cmd       = cmd_e'(cmd_i);
        read_fire = !ph_q.fall && (cmd == CMD_READ);
        load_fire = !ph_q.fall && (cmd == CMD_LOAD);
        ph_d.fall = rst ? 1'b0 : !ph_q.fall;
    end

    always_ff @(posedge clk) begin
        ph_q <= ph_d;
    end

    assign ck_phase_o = ph_q.fall;

    cas_mode_reg u_mode (
        .clk        (clk),
        .rst        (rst),
        .load_fire  (load_fire),
        .read_fire  (read_fire),
        .addr       (addr_i),
        .slow_grade (slow_grade_i),
        .mode       (mode_o),
        .lat_halves (lat_halves),
        .err_seq    (err_seq_o),
        .err_rsvd   (err_rsvd_o)
    );

    cas_beat_line #(
        .DW       (DW),
        .BL       (BL),
        .MAX_HALF (MAX_HALF)
    ) u_line (
        .clk        (clk),
        .rst        (rst),
        .read_fire  (read_fire),
        .lat_halves (lat_halves),
        .burst      (burst_i),
        .dq         (dq_o),
        .dqs        (dqs_o)
    );

endmodule

// File: rtl/cas_read_pipe_chk.sv
module cas_read_pipe_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    cmd_i,
    input logic [12:0]   addr_i,
    input logic          ck_phase_o,
    input logic [DW-1:0] dq_o,
    input logic          dqs_o,
    input logic [6:0]    mode_o,
    input logic          err_seq_o,
    input logic          err_rsvd_o
);

    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (mode_o == 7'b0100000 && !err_seq_o && !err_rsvd_o && !dqs_o && !ck_phase_o));

    p_quiet_bus_r4: assert property (@(posedge clk) disable iff (rst)
        !dqs_o |-> (dq_o == '0));

    p_phase_toggles_r11: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (ck_phase_o != $past(ck_phase_o)));

    p_fall_slot_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (ck_phase_o && cmd_i == 2'b10) |=> ($stable(mode_o) && $stable(err_rsvd_o)));

    p_rsvd_keeps_mode_r9: assert property (@(posedge clk) disable iff (rst)
        (!ck_phase_o && cmd_i == 2'b10 && addr_i[12:7] != 6'b000000 && addr_i[12:7] != 6'b000010)
        |=> ($stable(mode_o) && err_rsvd_o));

    p_seq_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        err_seq_o |=> err_seq_o);

    p_rsvd_sticky_r12: assert property (@(posedge clk) disable iff (rst)
        err_rsvd_o |=> err_rsvd_o);

endmodule

bind cas_read_pipe cas_read_pipe_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_i      (cmd_i),
    .addr_i     (addr_i),
    .ck_phase_o (ck_phase_o),
    .dq_o       (dq_o),
    .dqs_o      (dqs_o),
    .mode_o     (mode_o),
    .err_seq_o  (err_seq_o),
    .err_rsvd_o (err_rsvd_o)
);

// File: tb/cas_read_pipe_test.sv
module cas_read_pipe_test;

    localparam int DW    = 8;
    localparam int BL    = 4;
    localparam int DEPTH = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        cmd_i = 2'b00;
    logic [12:0]       addr_i = '0;
    logic              slow_i = 1'b0;
    logic [BL*DW-1:0]  burst_i = '0;
    logic              ck_phase_o, dqs_o, err_seq_o, err_rsvd_o;
    logic [DW-1:0]     dq_o;
    logic [6:0]        mode_o;

    always #10 clk = ~clk;

    cas_read_pipe #(.DW(DW), .BL(BL), .MAX_HALF(6)) uut (
        .clk          (clk),
        .rst          (rst),
        .cmd_i        (cmd_i),
        .addr_i       (addr_i),
        .slow_grade_i (slow_i),
        .burst_i      (burst_i),
        .ck_phase_o   (ck_phase_o),
        .dq_o         (dq_o),
        .dqs_o        (dqs_o),
        .mode_o       (mode_o),
        .err_seq_o    (err_seq_o),
        .err_rsvd_o   (err_rsvd_o)
    );

    // Expected state after the most recent edge, built from the requirements.
    logic          m_v [DEPTH];
    logic [DW-1:0] m_d [DEPTH];
    logic          m_half, m_seq, m_rsvd, m_armed;
    logic [6:0]    m_mode;
    int            n_vec = 0;
    int            n_bad = 0;
    string         req = "R1";
    bit            done = 1'b0;

    function automatic int halves_of(input logic [2:0] c);
        case (c)
            3'b010:  return 4;
            3'b011:  return 6;
            3'b110:  return 5;
            3'b101:  return 3;
            default: return -1;
        endcase
    endfunction

    function automatic bit line_free();
        for (int j = 3; j < DEPTH; j++) if (m_v[j]) return 1'b0;
        return 1'b1;
    endfunction

    task automatic model_step(input logic [1:0] c, input logic [12:0] a, input logic [BL*DW-1:0] b);
        bit fire, norm, dll, ok;
        int h;
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) begin m_v[j] = 1'b0; m_d[j] = '0; end
            m_half = 1'b0; m_mode = 7'b0100000; m_seq = 1'b0; m_rsvd = 1'b0; m_armed = 1'b0;
            return;
        end
        fire = !m_half;
        h = halves_of(m_mode[6:4]);
        for (int j = 0; j < DEPTH - 1; j++) begin m_v[j] = m_v[j+1]; m_d[j] = m_d[j+1]; end
        m_v[DEPTH-1] = 1'b0; m_d[DEPTH-1] = '0;
        if (fire && c == 2'b01) begin
            for (int k = 0; k < BL; k++) begin m_v[h+k] = 1'b1; m_d[h+k] = b[k*DW +: DW]; end
            if (m_armed) m_seq = 1'b1;
        end
        if (fire && c == 2'b10) begin
            norm = (a[12:7] == 6'b000000);
            dll  = (a[12:7] == 6'b000010);
            ok   = (halves_of(a[6:4]) > 0) && (a[6:4] != 3'b101 || slow_i);
            if ((norm || dll) && ok) m_mode = a[6:0];
            else m_rsvd = 1'b1;
            if (m_armed && !(norm && ok)) m_seq = 1'b1;
            if (dll && ok) m_armed = 1'b1;
            else if (norm && ok) m_armed = 1'b0;
        end
        m_half = !m_half;
    endtask

    task automatic compare();
        bit bad = 1'b0;
        logic [DW-1:0] exp_dq;
        exp_dq = m_v[0] ? m_d[0] : '0;
        n_vec++;
        if (dqs_o !== m_v[0]) begin
            bad = 1'b1; $display("FAIL %s dqs_o act=%b exp=%b t=%0t", req, dqs_o, m_v[0], $time);
        end
        if (dq_o !== exp_dq) begin
            bad = 1'b1; $display("FAIL %s dq_o act=%h exp=%h t=%0t", req, dq_o, exp_dq, $time);
        end
        if (mode_o !== m_mode) begin
            bad = 1'b1; $display("FAIL %s mode_o act=%b exp=%b t=%0t", req, mode_o, m_mode, $time);
        end
        if (err_seq_o !== m_seq) begin
            bad = 1'b1; $display("FAIL %s err_seq_o act=%b exp=%b t=%0t", req, err_seq_o, m_seq, $time);
        end
        if (err_rsvd_o !== m_rsvd) begin
            bad = 1'b1; $display("FAIL %s err_rsvd_o act=%b exp=%b t=%0t", req, err_rsvd_o, m_rsvd, $time);
        end
        if (ck_phase_o !== m_half) begin
            bad = 1'b1; $display("FAIL %s ck_phase_o act=%b exp=%b t=%0t", req, ck_phase_o, m_half, $time);
        end
        if (bad) n_bad++;
    endtask

    task automatic tick(input logic [1:0] c, input logic [12:0] a, input logic [BL*DW-1:0] b);
        cmd_i = c; addr_i = a; burst_i = b;
        model_step(c, a, b);
        @(negedge clk);
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick(2'b00, '0, '0);
    endtask

    task automatic align();
        if (m_half) tick(2'b00, '0, '0);
    endtask

    task automatic load(input logic [5:0] opm, input logic [6:0] low);
        align();
        tick(2'b10, {opm, low}, '0);
    endtask

    task automatic rd(input logic [BL*DW-1:0] b);
        align();
        tick(2'b01, '0, b);
    endtask

    task automatic do_reset();
        rst = 1'b1; idle(2); rst = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        void'($urandom(32'h1f2e3d4c));
        @(negedge clk);
        req = "R1"; do_reset(); idle(2);

        req = "R2"; rd(32'h44332211); idle(10);                 // latency 2 after reset
        req = "R6"; load(6'b000000, 7'b0110_101); idle(1);       // normal load, CL 3
        req = "R2"; rd(32'hd4c3b2a1); idle(12);
        load(6'b000000, 7'b1100_010); rd(32'h0f1e2d3c); idle(12); // CL 2.5, falling edge
        req = "R4"; rd(32'h80706050); tick(2'b00, '0, '1); idle(10);

        req = "R5"; load(6'b000000, 7'b0100_000);
        rd(32'h03020100); idle(3); rd(32'h07060504); idle(3); rd(32'h0b0a0908); idle(12);

        req = "R3"; slow_i = 1'b0; load(6'b000000, 7'b1010_000); idle(4);
        slow_i = 1'b1; load(6'b000000, 7'b1010_011); rd(32'hcafef00d); idle(10);
        slow_i = 1'b0; do_reset();

        req = "R10"; load(6'b000000, 7'b0000_111); idle(2);
        load(6'b000000, 7'b1110_000); idle(2); do_reset();

        req = "R9"; load(6'b000001, 7'b0110_000); idle(2);
        load(6'b100010, 7'b0110_000); idle(2);
        req = "R12"; idle(6); load(6'b000000, 7'b0110_000); idle(4); do_reset(); idle(2);

        req = "R7"; load(6'b000010, 7'b0110_001); idle(2);
        load(6'b000000, 7'b0100_001); rd(32'h11111111); idle(10);
        req = "R8"; load(6'b000010, 7'b0100_000); rd(32'h22222222); idle(10);
        load(6'b000000, 7'b0100_000); idle(2); do_reset();
        load(6'b000010, 7'b0100_000); load(6'b000010, 7'b0100_000); idle(2); do_reset();
        load(6'b000010, 7'b0100_000); load(6'b000000, 7'b0000_000); idle(2); do_reset();

        req = "R11"; align(); idle(1);
        tick(2'b10, {6'b000000, 7'b0110_000}, '0); idle(1);
        tick(2'b01, '0, 32'h55aa55aa); idle(10);
        tick(2'b10, {6'b000001, 7'b0110_000}, '0); idle(2);

        req = "RND";
        for (int i = 0; i < 1500; i++) begin
            int r;
            logic [5:0] opm;
            r = int'($urandom % 10);
            if ($urandom % 50 == 0) slow_i = ~slow_i;
            if ($urandom % 300 == 0) do_reset();
            if (r < 4) begin
                tick(2'b00, 13'($urandom), BL*DW'($urandom));
            end else if (r < 7) begin
                if (line_free()) tick(2'b01, '0, BL*DW'($urandom));
                else tick(2'b11, 13'($urandom), '0);
            end else begin
                case ($urandom % 8)
                    0, 1, 2, 3, 4: opm = 6'b000000;
                    5, 6:          opm = 6'b000010;
                    default:       opm = 6'($urandom);
                endcase
                tick(2'b10, {opm, 7'($urandom)}, '0);
            end
        end
        idle(12);
        finish_run();
    end

    initial begin
        #(64'd20 * 64'd200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog run did not end act=running exp=done");
            finish_run();
        end
    end

endmodule